// File: doc/BRIEF.md
# Floating-Point Unpack and Classify

This block takes one packed binary floating-point word (sign, biased exponent field, stored fraction field) and splits it into a form that arithmetic units downstream can use directly. It reports the operand class, passes the sign through, removes the exponent bias, and places the significand in a 64-bit left-aligned field. For normal operands bit 63 of that field holds the explicit leading one.

Subnormal operands are handled in one of two ways, chosen by an input. They are either normalized, so that the leading one moves to bit 63 and the exponent drops by the shift, or they are flushed to zero and a flag is raised. A second input selects an alternative half-precision format in which the all-ones exponent is an ordinary normal exponent, so that format has no infinities and no NaNs. NaNs are sorted into quiet and signaling by the top stored fraction bit. Field widths are parameters. Results appear in registered outputs one clock after the operand is presented.

Top module: `fp_unpack`

## Requirements
- R1: While `rst` is high, the outputs clear on every clock edge to class code 0 (zero), sign 0, exponent 0, significand 0 and flag 0.
- R2: The result for the operand and controls sampled at one rising edge appears on the outputs just after that edge and holds until the next edge.
- R3: An exponent field of 0 with a zero fraction gives class code 0 (zero), exponent 0 and significand 0, with the flag low.
- R4: An exponent field strictly between 0 and all ones gives class code 1 (normal) and exponent = field − bias, where bias = 2^(EXP_W−1) − 1. The significand has bit 63 set, the stored fraction in the bits just below it, and zeros beneath.
- R5: With flush off, an exponent field of 0 and a nonzero fraction give class code 1. The significand is the fraction shifted up until its leading one sits at bit 63. The exponent is −bias − z, where z is the number of leading zeros in the stored fraction field.
- R6: With flush on, an exponent field of 0 and a nonzero fraction give class code 0, exponent 0 and significand 0, with the flag high. The flag is low for every other input.
- R7: With the alternative mode off, an all-ones exponent and a zero fraction give class code 2 (infinity), exponent = all-ones − bias, and significand 0.
- R8: With the alternative mode off, an all-ones exponent and a nonzero fraction give a NaN. The class is code 3 (quiet) when the top stored fraction bit is 1 and code 4 (signaling) when it is 0. The exponent is all-ones − bias. The significand holds the stored fraction directly below bit 63, with bit 63 clear.
- R9: With the alternative mode on, an all-ones exponent is treated as in R4, giving class 1 and exponent = all-ones − bias. Encodings with other exponents give the same result as with the mode off.
- R10: The sign output equals the top bit of the operand in every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_sub_i | input | 1 | Flush subnormal operands to zero |
| alt_fmt_i | input | 1 | All-ones exponent is a normal exponent |
| op_i | input | EXP_W+FRAC_W+1 | Packed operand: sign, exponent field, fraction field |
| cls_o | output | 3 | Class code (0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signaling NaN) |
| sign_o | output | 1 | Operand sign |
| exp_o | output | EXP_W+2 | Unbiased exponent, two's complement |
| mant_o | output | 64 | Left-aligned significand |
| sub_flush_o | output | 1 | A subnormal operand was flushed |

## Verification
With both controls low, every one of the 65536 half-width encodings is applied. This separates the zero, normal, subnormal, infinity, quiet NaN and signaling NaN paths, and the subnormal cases also test the leading-zero count at every shift distance. All encodings with a zero exponent field are then repeated with flush on, which tells flushed operands apart from true zeros through the flag. All encodings with an all-ones exponent field are repeated with the alternative mode on, which shows those operands turning into normals with the largest exponent. Directed cases pin the reset values, the one-cycle latency, and the boundary encodings: smallest and largest subnormal, largest normal, infinity and both NaN kinds.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;
  localparam int WIDE_W = 64;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_NORMAL = 3'd1,
    CLS_INF    = 3'd2,
    CLS_QNAN   = 3'd3,
    CLS_SNAN   = 3'd4
  } fp_class_e;
endpackage

// File: rtl/fp_unpack_lzc.sv
// Leading-zero counter over the stored fraction field.
module fp_unpack_lzc #(
  parameter int W     = 10,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp_unpack_class.sv
// Decides the operand class from the field summaries and the mode inputs.
module fp_unpack_class
  import fp_unpack_pkg::*;
(
  input  logic      exp_zero_i,
  input  logic      exp_ones_i,
  input  logic      frac_nz_i,
  input  logic      frac_top_i,
  input  logic      flush_i,
  input  logic      alt_i,
  output fp_class_e cls_o,
  output logic      flushed_o
);
  always_comb begin
    flushed_o = 1'b0;
    if (exp_zero_i) begin
      if (frac_nz_i && !flush_i) begin
        cls_o = CLS_NORMAL;
      end else begin
        cls_o     = CLS_ZERO;
        flushed_o = frac_nz_i;
      end
    end else if (!exp_ones_i || alt_i) begin
      cls_o = CLS_NORMAL;
    end else if (!frac_nz_i) begin
      cls_o = CLS_INF;
    end else begin
      cls_o = frac_top_i ? CLS_QNAN : CLS_SNAN;
    end
  end
endmodule

// File: rtl/fp_unpack_norm.sv
// Subnormal path: shifts the leading one to the top and adjusts the exponent.
module fp_unpack_norm #(
  parameter int FRAC_W = 10,
  parameter int UEXP_W = 7,
  parameter int BIAS   = 15,
  localparam int CNT_W = $clog2(FRAC_W + 1),
  localparam int WW    = fp_unpack_pkg::WIDE_W
) (
  input  logic [WW-1:0]            aligned_i,
  input  logic [CNT_W-1:0]         lz_i,
  output logic [WW-1:0]            mant_o,
  output logic signed [UEXP_W-1:0] exp_o
);
  localparam int SH_W = $clog2(WW);
  localparam logic signed [UEXP_W-1:0] NEG_BIAS = -UEXP_W'(BIAS);

  logic [SH_W-1:0] shamt;

  always_comb begin
    shamt  = SH_W'(lz_i) + SH_W'(1);
    mant_o = aligned_i << shamt;
    exp_o  = NEG_BIAS - $signed(UEXP_W'(lz_i));
  end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fp_unpack_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int FRAC_W = 10,
  localparam int OP_W   = EXP_W + FRAC_W + 1,
  localparam int UEXP_W = EXP_W + 2,
  localparam int WW     = WIDE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush_sub_i,
  input  logic                     alt_fmt_i,
  input  logic [OP_W-1:0]          op_i,
  output logic [2:0]               cls_o,
  output logic                     sign_o,
  output logic signed [UEXP_W-1:0] exp_o,
  output logic [WW-1:0]            mant_o,
  output logic                     sub_flush_o
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int PAD_W = WW - 1 - FRAC_W;
  localparam int CNT_W = $clog2(FRAC_W + 1);
  localparam logic signed [UEXP_W-1:0] BIAS_S = UEXP_W'(BIAS);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [WW-1:0]     aligned, sub_mant, mant_n;
  logic [CNT_W-1:0]  lz;
  logic signed [UEXP_W-1:0] sub_exp, exp_n, exp_unb;
  fp_class_e cls_n;
  logic      flushed_n;

  assign exp_f   = op_i[FRAC_W +: EXP_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign aligned = {1'b0, frac_f, {PAD_W{1'b0}}};
  assign exp_unb = $signed(UEXP_W'(exp_f)) - BIAS_S;

  fp_unpack_lzc #(.W(FRAC_W)) u_lzc (
    .vec_i (frac_f),
    .cnt_o (lz)
  );

  fp_unpack_class u_class (
    .exp_zero_i (exp_f == '0),
    .exp_ones_i (&exp_f),
    .frac_nz_i  (|frac_f),
    .frac_top_i (frac_f[FRAC_W-1]),
    .flush_i    (flush_sub_i),
    .alt_i      (alt_fmt_i),
    .cls_o      (cls_n),
    .flushed_o  (flushed_n)
  );

  fp_unpack_norm #(.FRAC_W(FRAC_W), .UEXP_W(UEXP_W), .BIAS(BIAS)) u_norm (
    .aligned_i (aligned),
    .lz_i      (lz),
    .mant_o    (sub_mant),
    .exp_o     (sub_exp)
  );

  always_comb begin
    exp_n  = '0;
    mant_n = '0;
    unique case (cls_n)
      CLS_NORMAL: begin
        if (exp_f == '0) begin
          exp_n  = sub_exp;
          mant_n = sub_mant;
        end else begin
          exp_n  = exp_unb;
          mant_n = {1'b1, frac_f, {PAD_W{1'b0}}};
        end
      end
      CLS_INF:            exp_n = exp_unb;
      CLS_QNAN, CLS_SNAN: begin
        exp_n  = exp_unb;
        mant_n = aligned;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_o       <= CLS_ZERO;
      sign_o      <= 1'b0;
      exp_o       <= '0;
      mant_o      <= '0;
      sub_flush_o <= 1'b0;
    end else begin
      cls_o       <= cls_n;
      sign_o      <= op_i[OP_W-1];
      exp_o       <= exp_n;
      mant_o      <= mant_n;
      sub_flush_o <= flushed_n;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (cls_o == CLS_ZERO && mant_o == '0 && !sub_flush_o)); // R1
  AST_NORM_LEAD: assert property (@(posedge clk) disable iff (rst)
    (cls_o == CLS_NORMAL) |-> mant_o[WW-1]); // R4
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
    sub_flush_o |-> (cls_o == CLS_ZERO && mant_o == '0)); // R6
  AST_NAN_NO_LEAD: assert property (@(posedge clk) disable iff (rst)
    (cls_o == CLS_QNAN || cls_o == CLS_SNAN) |-> (!mant_o[WW-1] && mant_o != '0)); // R8
  AST_QUIET_BIT: assert property (@(posedge clk) disable iff (rst)
    (cls_o == CLS_QNAN) |-> mant_o[WW-2]); // R8
  AST_ALT_NO_SPECIAL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alt_fmt_i)) |-> (cls_o == CLS_ZERO || cls_o == CLS_NORMAL)); // R9
  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sign_o == $past(op_i[OP_W-1]))); // R10
endmodule

// File: tb/fp_unpack_tb.sv
`timescale 1ns/1ps
module fp_unpack_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_sub_i = 1'b0;
  logic        alt_fmt_i = 1'b0;
  logic [15:0] op_i = 16'h0000;
  logic [2:0]  cls_o;
  logic        sign_o;
  logic signed [6:0] exp_o;
  logic [63:0] mant_o;
  logic        sub_flush_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp_unpack u_dut (
    .clk(clk), .rst(rst), .flush_sub_i(flush_sub_i), .alt_fmt_i(alt_fmt_i),
    .op_i(op_i), .cls_o(cls_o), .sign_o(sign_o), .exp_o(exp_o),
    .mant_o(mant_o), .sub_flush_o(sub_flush_o)
  );

  // {class, sign, exponent, significand, flag} built from the requirements
  function automatic logic [75:0] model(logic [15:0] op, logic fl, logic alt);
    int e = int'(op[14:10]);
    logic [9:0] f = op[9:0];
    int ex = 0;
    logic [63:0] fr = '0;
    logic [2:0] c = 3'd0;
    logic dn = 1'b0;
    if (e == 0 && f == 0) begin
      c = 3'd0;                                     // R3
    end else if (e == 0) begin
      if (fl) dn = 1'b1;                            // R6
      else begin                                    // R5
        int k = 0;
        for (int i = 0; i < 10; i++) if (f[i]) k = i;
        fr = 64'(f) << (63 - k);
        ex = -15 - (9 - k);
        c = 3'd1;
      end
    end else if (e < 31 || alt) begin               // R4, R9
      c = 3'd1; ex = e - 15; fr = {1'b1, f, 53'b0};
    end else if (f == 0) begin                      // R7
      c = 3'd2; ex = 16;
    end else begin                                  // R8
      c = f[9] ? 3'd3 : 3'd4; ex = 16; fr = {1'b0, f, 53'b0};
    end
    return {c, op[15], 7'(ex), fr, dn};
  endfunction

  function automatic string req_of(logic [15:0] op, logic fl, logic alt);
    if (op[14:10] == 0) return (op[9:0] == 0) ? "R3" : (fl ? "R6" : "R5");
    if (op[14:10] != 5'h1f) return "R4";
    if (alt) return "R9";
    return (op[9:0] == 0) ? "R7" : "R8";
  endfunction

  function automatic logic [75:0] observed();
    return {cls_o, sign_o, exp_o, mant_o, sub_flush_o};
  endfunction

  task automatic check(string req, logic [75:0] got, logic [75:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [15:0] op, logic fl, logic alt);
    @(negedge clk);
    op_i = op; flush_sub_i = fl; alt_fmt_i = alt;
    @(posedge clk); #1;
    check(req_of(op, fl, alt), observed(), model(op, fl, alt));
  endtask

  task automatic t_reset();
    rst = 1'b1; op_i = 16'hfc01; flush_sub_i = 1'b1; alt_fmt_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1", observed(), 76'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_latency();
    apply(16'h0000, 1'b0, 1'b0);
    @(negedge clk); op_i = 16'h3c00; #1;
    check("R2", observed(), model(16'h0000, 1'b0, 1'b0));
    @(posedge clk); #1;
    check("R2", observed(), model(16'h3c00, 1'b0, 1'b0));
  endtask

  task automatic t_corners();
    apply(16'h0001, 1'b0, 1'b0);  // smallest subnormal, R5
    apply(16'h83ff, 1'b0, 1'b0);  // largest subnormal, negative, R5 R10
    apply(16'h7bff, 1'b0, 1'b0);  // largest normal, R4
    apply(16'hfc00, 1'b0, 1'b0);  // negative infinity, R7 R10
    apply(16'h7e00, 1'b0, 1'b0);  // quiet NaN, R8
    apply(16'h7c01, 1'b0, 1'b0);  // signaling NaN, R8
    apply(16'h8000, 1'b1, 1'b0);  // true zero under flush keeps flag low, R6
    apply(16'h0200, 1'b1, 1'b0);  // flushed subnormal, R6
    apply(16'h7fff, 1'b0, 1'b1);  // alt format largest value, R9
    apply(16'h7bff, 1'b1, 1'b1);  // alt and flush do not touch normals, R4 R9
  endtask

  task automatic t_sweep_default();
    for (int v = 0; v < 65536; v++) apply(16'(v), 1'b0, 1'b0);
  endtask

  task automatic t_sweep_flush();
    for (int v = 0; v < 2048; v++) apply({v[10], 5'h00, v[9:0]}, 1'b1, 1'b0);
  endtask

  task automatic t_sweep_alt();
    for (int v = 0; v < 2048; v++) apply({v[10], 5'h1f, v[9:0]}, 1'b0, 1'b1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_sweep_default();
    t_sweep_flush();
    t_sweep_alt();
    done = 1'b1;
    summary();
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog got timeout expected completion");
      summary();
    end
  end
endmodule